// File: doc/BRIEF.md
# Palette Lookup and Overlay Pixel Pipeline

This block is the pixel-rate colour datapath of a display output path. Each accepted pixel carries a 24-bit word, an overlay code, a blanking flag and a sync flag. Under the active colour mode, the block forms three 8-bit table indices from the pixel word and ANDs each index with a mask register. It then reads the red, green and blue lookup tables (256 entries each). A nonzero overlay code replaces that colour with an entry from a 15-entry overlay table, and blanking forces black. The colour leaves together with its own blank and sync flags after a fixed four-stage pipeline.

Pixels enter and leave on valid/ready streams. The whole pipeline moves as one unit: it advances when its last stage is empty or the consumer takes the output. `in_ready` is therefore high exactly when `out_valid` is low or `out_ready` is high. While the consumer withholds `out_ready`, the output holds steady and no pixel is lost or reordered.

A plain write port loads the lookup tables, the overlay table, the mask and the mode. Tables are expected to change only while no pixels are in flight.

Top module: `pix_lut_pipe`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The mask resets to 0xFF and the mode resets to code 0.
- R2: With `out_ready` held high, a pixel accepted at a rising edge is presented on the outputs after the third following edge and is handed over at the fourth. Output order equals input order.
- R3: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rgb`, `out_blank` and `out_sync` keep their values at the next edge.
- R4: Mode code 0 (full colour): pixel bits [23:16] index the red table, [15:8] index the green table and [7:0] index the blue table.
- R5: Mode code 1 (indexed): pixel bits [23:16] index all three tables, and the remaining bits have no effect.
- R6: Mode code 2 (5-5-5): fields [14:10], [9:5] and [4:0] serve red, green and blue. Each 5-bit field f becomes the index {f, f[4:2]}, and bits [23:15] have no effect.
- R7: Mode code 3 (3-3-2): fields [7:5], [4:2] and [1:0] serve red, green and blue. A 3-bit field f becomes {f, f, f[2:1]}, a 2-bit field f becomes {f, f, f, f}, and bits [23:8] have no effect.
- R8: Each of the three indices is ANDed bitwise with the mask register before the lookup.
- R9: Overlay code 0 selects the table result. Codes 1 to 15 replace it with overlay entry 1 to 15, unaffected by mode or mask.
- R10: When the blank flag of a pixel is set, its output colour is 0 whatever the mode and overlay. The blank and sync flags leave with the same pixel they entered with.
- R11: A write with `wr_en` high stores `wr_data` at the next edge into the target selected by `wr_target`. Target 0 is the lookup tables at `wr_addr`, with red [23:16], green [15:8] and blue [7:0]. Target 1 is overlay entry `wr_addr`; addresses 0 or above 15 are dropped. Target 2 is the mask, from `wr_data[7:0]`. Target 3 is the mode, from `wr_data[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the setup port |
| wr_target | input | 2 | Write target: 0 tables, 1 overlay, 2 mask, 3 mode |
| wr_addr | input | 8 | Table or overlay entry address |
| wr_data | input | 24 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Pipeline can accept a pixel |
| in_pixel | input | 24 | Pixel word |
| in_overlay | input | 4 | Overlay code, 0 for none |
| in_blank | input | 1 | Blanking flag |
| in_sync | input | 1 | Sync flag |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Consumer takes the output |
| out_rgb | output | 24 | Colour: red [23:16], green [15:8], blue [7:0] |
| out_blank | output | 1 | Blanking flag aligned with the colour |
| out_sync | output | 1 | Sync flag aligned with the colour |

## Verification
The bench builds the block with its default parameters: 8-bit channels and a 4-bit overlay code. With these values it can fill all 256 entries of each lookup table with random colours and reach every one of the 15 overlay entries. Random pixel streams run in each of the four modes under random back-pressure and random input gaps. Directed phases cover the default and zero masks, the stall-free latency, and blanking over overlaid pixels.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int TBL_N  = 1 << CH_W;

  typedef enum logic [1:0] {
    MODE_TRUE24  = 2'd0,
    MODE_INDEX8  = 2'd1,
    MODE_TRUE15  = 2'd2,
    MODE_TRUE8   = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    TGT_TABLE   = 2'd0,
    TGT_OVERLAY = 2'd1,
    TGT_MASK    = 2'd2,
    TGT_MODE    = 2'd3
  } wtgt_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Widen a w-bit field (held in the low bits of v) to CH_W bits by
  // repeating it from the top down.
  function automatic logic [CH_W-1:0] widen(input logic [CH_W-1:0] v, input int w);
    logic [CH_W-1:0] res;
    for (int i = 0; i < CH_W; i++) begin
      res[CH_W-1-i] = v[w-1-(i % w)];
    end
    return res;
  endfunction
endpackage

// File: rtl/pix_index_gen.sv
module pix_index_gen
  import pix_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             v_in,
  input  logic [PIX_W-1:0] pix,
  input  cmode_e           mode,
  input  logic [CH_W-1:0]  mask,
  output rgb_t             idx_q
);
  rgb_t raw;
  rgb_t masked;

  always_comb begin
    unique case (mode)
      MODE_TRUE24: begin
        raw.r = pix[23:16];
        raw.g = pix[15:8];
        raw.b = pix[7:0];
      end
      MODE_INDEX8: begin
        raw.r = pix[23:16];
        raw.g = pix[23:16];
        raw.b = pix[23:16];
      end
      MODE_TRUE15: begin
        raw.r = widen(CH_W'(pix[14:10]), 5);
        raw.g = widen(CH_W'(pix[9:5]), 5);
        raw.b = widen(CH_W'(pix[4:0]), 5);
      end
      default: begin
        raw.r = widen(CH_W'(pix[7:5]), 3);
        raw.g = widen(CH_W'(pix[4:2]), 3);
        raw.b = widen(CH_W'(pix[1:0]), 2);
      end
    endcase
    masked.r = raw.r & mask;
    masked.g = raw.g & mask;
    masked.b = raw.b & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (adv) idx_q <= masked;
  end

  // R8: no index bit survives outside the mask in force when it was formed
  p_mask_applied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv && v_in |=> ((idx_q.r | idx_q.g | idx_q.b) & ~$past(mask)) == '0);

  // R5: indexed mode drives one index into all three tables
  p_index_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && v_in && mode == MODE_INDEX8 |=> idx_q.r == idx_q.g && idx_q.g == idx_q.b);
endmodule

// File: rtl/pix_color_tables.sv
module pix_color_tables
  import pix_lut_pkg::*;
(
  input  logic            clk,
  input  logic            we,
  input  logic [CH_W-1:0] waddr,
  input  rgb_t            wdata,
  input  logic            re,
  input  rgb_t            raddr,
  output rgb_t            rdata
);
  logic [2:0][CH_W-1:0] wd_a;
  logic [2:0][CH_W-1:0] ra_a;
  logic [CH_W-1:0]      rd_arr [3];

  assign wd_a = wdata;
  assign ra_a = raddr;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CH_W-1:0] mem [TBL_N];
    logic [CH_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wd_a[c];
      if (re) rd_q <= mem[ra_a[c]];
    end
    assign rd_arr[c] = rd_q;
  end

  assign rdata = {rd_arr[2], rd_arr[1], rd_arr[0]};
endmodule

// File: rtl/pix_overlay_table.sv
module pix_overlay_table
  import pix_lut_pkg::*;
#(
  parameter int OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             adv,
  input  logic [OVL_W-1:0] code,
  output logic [PIX_W-1:0] rd_q,
  output logic             hit_q
);
  localparam int N = (1 << OVL_W) - 1;

  logic [PIX_W-1:0] ent [1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= N; i++) ent[i] <= '0;
    end else if (we && waddr != '0 && int'(waddr) <= N) begin
      ent[OVL_W'(waddr)] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      hit_q <= 1'b0;
    end else if (adv) begin
      hit_q <= code != '0;
      rd_q  <= (code == '0) ? '0 : ent[code];
    end
  end
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage
  import pix_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             v,
  input  logic             blank,
  input  logic             sync,
  input  logic [PIX_W-1:0] pal,
  input  logic [PIX_W-1:0] ovl,
  input  logic             hit,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_rgb,
  output logic             out_blank,
  output logic             out_sync
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_blank <= 1'b0;
      out_sync  <= 1'b0;
    end else if (adv) begin
      out_valid <= v;
      out_blank <= blank;
      out_sync  <= sync;
      if (blank)    out_rgb <= '0;
      else if (hit) out_rgb <= ovl;
      else          out_rgb <= pal;
    end
  end
endmodule

// File: rtl/pix_lut_pipe.sv
module pix_lut_pipe
  import pix_lut_pkg::*;
#(
  parameter int OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_target,
  input  logic [CH_W-1:0]  wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic [OVL_W-1:0] in_overlay,
  input  logic             in_blank,
  input  logic             in_sync,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_rgb,
  output logic             out_blank,
  output logic             out_sync
);
  localparam int SIDE_N = 3;

  logic             adv;
  logic [CH_W-1:0]  mask_q;
  cmode_e           mode_q;
  logic [SIDE_N-1:0] sv_q, sb_q, ss_q;
  logic [PIX_W-1:0] s1_pix;
  logic [OVL_W-1:0] s1_ovl, s2_ovl;
  rgb_t             idx;
  rgb_t             pal_rd;
  logic [PIX_W-1:0] ovl_rd;
  logic             ovl_hit;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // setup registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= MODE_TRUE24;
    end else if (wr_en) begin
      if (wr_target == TGT_MASK) mask_q <= wr_data[CH_W-1:0];
      if (wr_target == TGT_MODE) mode_q <= cmode_e'(wr_data[1:0]);
    end
  end

  // stage 1 capture and sideband shift through stages 1..3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q   <= '0;
      sb_q   <= '0;
      ss_q   <= '0;
      s1_pix <= '0;
      s1_ovl <= '0;
      s2_ovl <= '0;
    end else if (adv) begin
      sv_q   <= {sv_q[SIDE_N-2:0], in_valid};
      sb_q   <= {sb_q[SIDE_N-2:0], in_blank};
      ss_q   <= {ss_q[SIDE_N-2:0], in_sync};
      s1_pix <= in_pixel;
      s1_ovl <= in_overlay;
      s2_ovl <= s1_ovl;
    end
  end

  pix_index_gen u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .v_in  (sv_q[0]),
    .pix   (s1_pix),
    .mode  (mode_q),
    .mask  (mask_q),
    .idx_q (idx)
  );

  pix_color_tables u_tbl (
    .clk   (clk),
    .we    (wr_en && wr_target == TGT_TABLE),
    .waddr (wr_addr),
    .wdata (rgb_t'(wr_data)),
    .re    (adv),
    .raddr (idx),
    .rdata (pal_rd)
  );

  pix_overlay_table #(.OVL_W(OVL_W)) u_ovl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && wr_target == TGT_OVERLAY),
    .waddr (wr_addr),
    .wdata (wr_data),
    .adv   (adv),
    .code  (s2_ovl),
    .rd_q  (ovl_rd),
    .hit_q (ovl_hit)
  );

  pix_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .v         (sv_q[2]),
    .blank     (sb_q[2]),
    .sync      (ss_q[2]),
    .pal       (PIX_W'(pal_rd)),
    .ovl       (ovl_rd),
    .hit       (ovl_hit),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_blank (out_blank),
    .out_sync  (out_sync)
  );

  // R3: a stalled output holds
  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_blank) && $stable(out_sync));

  // R1/R3: an empty output stage always accepts
  p_empty_accepts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10: blanked output is black
  p_blank_black_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_blank |-> out_rgb == '0);

  // R2: a stage-one pixel reaches stage two on an advancing edge
  p_stage_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && sv_q[0] |=> sv_q[1]);
endmodule

// File: tb/tb_pix_lut_pipe.sv
module tb_pix_lut_pipe;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_target = '0;
  logic [7:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pixel = '0;
  logic [3:0]  in_overlay = '0;
  logic        in_blank = 1'b0;
  logic        in_sync = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_rgb;
  logic        out_blank;
  logic        out_sync;

  pix_lut_pipe dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0]  m_r [256];
  logic [7:0]  m_g [256];
  logic [7:0]  m_b [256];
  logic [23:0] m_ovl [16];
  logic [7:0]  m_mask = 8'hFF;
  logic [1:0]  m_mode = 2'd0;

  logic [25:0] exp_q [$];
  int          acc_q [$];
  int          cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  function automatic logic [7:0] w5(input logic [4:0] f); return {f, f[4:2]}; endfunction
  function automatic logic [7:0] w3(input logic [2:0] f); return {f, f, f[2:1]}; endfunction
  function automatic logic [7:0] w2(input logic [1:0] f); return {f, f, f, f}; endfunction

  function automatic logic [23:0] model(input logic [23:0] p, input logic [3:0] ov, input logic bl);
    logic [7:0] ir, ig, ib;
    if (bl) return 24'h0;
    if (ov != 0) return m_ovl[ov];
    case (m_mode)
      2'd0: begin ir = p[23:16]; ig = p[15:8]; ib = p[7:0]; end
      2'd1: begin ir = p[23:16]; ig = p[23:16]; ib = p[23:16]; end
      2'd2: begin ir = w5(p[14:10]); ig = w5(p[9:5]); ib = w5(p[4:0]); end
      default: begin ir = w3(p[7:5]); ig = w3(p[4:2]); ib = w2(p[1:0]); end
    endcase
    ir &= m_mask; ig &= m_mask; ib &= m_mask;
    return {m_r[ir], m_g[ig], m_b[ib]};
  endfunction

  task automatic host_write(input logic [1:0] tgt, input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_target = tgt; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (tgt)
      2'd0: begin m_r[a] = d[23:16]; m_g[a] = d[15:8]; m_b[a] = d[7:0]; end
      2'd1: if (a != 0 && a <= 15) m_ovl[a[3:0]] = d;
      2'd2: m_mask = d[7:0];
      default: m_mode = d[1:0];
    endcase
  endtask

  task automatic run_stream(input int n, input string tag, input int pv, input int pr,
                            input int povl, input int pbl, input bit lat);
    int sent = 0;
    bit held = 1'b0;
    logic [25:0] hv = '0;
    while (sent < n || exp_q.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (held)
        check(out_valid && {out_rgb, out_blank, out_sync} == hv, "R3 hold", {out_valid, out_rgb}, {1'b1, hv[25:2]});
      in_valid   = (sent < n) && (($urandom % 100) < pv);
      in_pixel   = $urandom;
      in_overlay = (($urandom % 100) < povl) ? 4'(1 + $urandom % 15) : 4'd0;
      in_blank   = ($urandom % 100) < pbl;
      in_sync    = $urandom;
      out_ready  = ($urandom % 100) < pr;
      #1;
      if (pr < 100)
        check(in_ready == (!out_valid || out_ready), "R3 ready", in_ready, !out_valid || out_ready);
      if (in_valid && in_ready) begin
        exp_q.push_back({model(in_pixel, in_overlay, in_blank), in_blank, in_sync});
        acc_q.push_back(cyc);
        sent++;
      end
      if (out_valid && out_ready) begin
        logic [25:0] e;
        int c0;
        if (exp_q.size() == 0) begin
          check(1'b0, {tag, " spurious"}, out_rgb, 0);
        end else begin
          e  = exp_q.pop_front();
          c0 = acc_q.pop_front();
          check({out_rgb, out_blank, out_sync} == e, tag, {out_rgb, out_blank, out_sync}, e);
          if (lat) check(cyc - c0 == 4, "R2 latency", cyc - c0, 4);
        end
      end
      held = out_valid && !out_ready;
      hv   = {out_rgb, out_blank, out_sync};
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_ovl[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", {out_valid, in_ready}, 2'b01);

    // R11: fill all three tables and all overlay entries
    for (int a = 0; a < 256; a++) host_write(2'd0, 8'(a), $urandom);
    for (int a = 1; a < 16; a++) host_write(2'd1, 8'(a), $urandom);
    host_write(2'd1, 8'd0, 24'hABCDEF);   // dropped address
    host_write(2'd1, 8'd200, 24'h123456); // dropped address

    // R1 defaults (mask 0xFF, mode 0) and R4 full colour
    run_stream(4, "R1 default", 100, 100, 0, 0, 1'b0);
    run_stream(20, "R2 order", 100, 100, 0, 0, 1'b1);
    run_stream(60, "R4 mode0", 70, 60, 0, 0, 1'b0);

    host_write(2'd2, 8'd0, 24'h0000B7);
    host_write(2'd3, 8'd0, 24'h000001);
    run_stream(60, "R5 R11 mode1 masked", 70, 60, 0, 0, 1'b0);

    host_write(2'd2, 8'd0, 24'h0000FF);
    host_write(2'd3, 8'd0, 24'h000002);
    run_stream(60, "R6 R11 mode2", 80, 50, 0, 0, 1'b0);

    host_write(2'd3, 8'd0, 24'h000003);
    run_stream(60, "R7 R11 mode3", 80, 50, 0, 0, 1'b0);

    host_write(2'd3, 8'd0, 24'h000000);
    host_write(2'd2, 8'd0, 24'h000000);
    run_stream(20, "R8 mask zero", 90, 70, 0, 0, 1'b0);
    host_write(2'd2, 8'd0, 24'h00005A);
    run_stream(40, "R8 mask 5A", 90, 70, 0, 0, 1'b0);

    host_write(2'd2, 8'd0, 24'h0000FF);
    run_stream(120, "R9 overlay", 80, 60, 60, 0, 1'b0);
    host_write(2'd3, 8'd0, 24'h000002);
    run_stream(60, "R9 overlay mode2", 80, 60, 50, 0, 1'b0);

    run_stream(100, "R10 blank", 80, 60, 50, 35, 1'b0);
    host_write(2'd3, 8'd0, 24'h000000);
    run_stream(30, "R10 R2 blank stall-free", 100, 100, 40, 40, 1'b1);

    summary();
  end
endmodule